// File: doc/BRIEF.md
# Polarity-Selectable Serial Receive Front End

This block is the receive half of an asynchronous serial port. It reads one line pin and samples it on a strobe that arrives sixteen times per bit. It rebuilds characters of 8 or 9 data bits, least significant bit first, each framed by one start bit and one stop bit. The line code is chosen at run time. In plain non-return-to-zero (NRZ) coding, each bit holds one level for the whole bit time. In infrared pulse coding, a logic zero is a short pulse and a logic one leaves the line at rest. Either code can be used with its levels inverted. The block also reports when a receive is in progress, when the line has rested for a whole character time, and when a stop bit was wrong.

Finished characters leave on a valid/ready stream. The output words are `m_data`, `m_bit8` and `m_frame_err`. Once `m_valid` is high, these words and `m_valid` itself stay unchanged until a cycle with `m_ready` high accepts them. Back-pressure does not stall the line. If a new character finishes while an earlier one is still waiting, the new one is dropped and the waiting one is kept.

The format, polarity and length controls may only be changed while `rst_n` is low. The oversample strobe is one clock wide.

Top module: `rxf_top`

## Requirements
- R1: NRZ coding with normal polarity takes a high pin as logic 1. A low start bit is followed by data bits, least significant first, and then the stop bit. A completed character appears on `m_data` with `m_valid` high.
- R2: When `cfg_invert` is 1 in NRZ coding, a low pin is logic 1 and a high pin is logic 0. This also applies to the resting level and to the start and stop bits.
- R3: In pulse coding with `cfg_invert` at 0, the line rests low. A high pulse anywhere inside a bit time decodes that bit as 0. A bit time with no pulse decodes as 1.
- R4: In pulse coding with `cfg_invert` at 1, the line rests high. A low pulse inside a bit time decodes that bit as 0.
- R5: In NRZ coding each bit is decided by a majority vote over oversamples 8, 9 and 10 of the 16 in that bit. Oversample 1 is the sample that found the start edge. A single wrong sample among the three is outvoted, and samples outside the three have no effect.
- R6: In NRZ coding, a start bit whose oversamples 8 to 10 vote 1 is dropped. No character is delivered for it, and the search for a start bit resumes.
- R7: When `cfg_nine` is 1, nine data bits are received and the ninth is placed on `m_bit8`. When `cfg_nine` is 0, eight bits are received and `m_bit8` is 0.
- R8: A stop bit that decodes as 0 still delivers the character, with `m_frame_err` set to 1. A stop bit that decodes as 1 gives `m_frame_err` 0.
- R9: `rx_busy` goes high on the oversample strobe at which the start search first sees logic 0.
- R10: `idle_seen` pulses after one character time of consecutive logic-1 samples during the start search. That time is 10 bit times with 8 data bits and 11 with 9. The pulse clears `rx_busy`, and it fires once for each resting stretch.
- R11: While `m_valid` is high and `m_ready` is low, the output words hold. A character that finishes during that time is discarded.
- R12: After reset, `m_valid`, `rx_busy` and `idle_seen` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversample strobe, 16 per bit time |
| rx_pin | input | 1 | Serial line input |
| cfg_irda | input | 1 | 1 selects pulse coding, 0 selects NRZ |
| cfg_invert | input | 1 | 1 inverts line polarity |
| cfg_nine | input | 1 | 1 selects 9 data bits |
| m_valid | output | 1 | Character available |
| m_ready | input | 1 | Consumer accepts the character |
| m_data | output | 8 | Data bits 0 to 7 |
| m_bit8 | output | 1 | Ninth data bit |
| m_frame_err | output | 1 | Stop bit decoded as 0 |
| rx_busy | output | 1 | Receive in progress |
| idle_seen | output | 1 | Pulse when an idle character is detected |

## Verification
The bench covers all four combinations of line code and polarity, with random data, random frame lengths and occasional bad stop bits. If the inversion or the pulse decoding were wrong, every byte would come out complemented or as all ones. The vote is tested in three ways. One corrupted centre sample must not change the bit, two corrupted centre samples must flip it, and corruption outside the centre must do nothing. A design that took a single sample, or the wrong three, fails one of these tests. A short low glitch must set the busy flag at once and must not deliver a character. The idle pulse is then checked on exactly the 160th resting sample, and not on the 159th, so an off-by-one counter is caught. A held output under back-pressure must keep the first character and not let the second overwrite it.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CHAR_W = 9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic              ferr;
    logic [CHAR_W-1:0] bits;
  } rx_char_t;
endpackage

// File: rtl/rxf_line_cond.sv
module rxf_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  input  logic os_tick,
  input  logic cfg_irda,
  input  logic cfg_invert,
  output logic samp_tick,
  output logic samp_bit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rest_lvl;
  logic                   lvl;
  logic                   pulse_q;

  // resting level: NRZ rests at logic 1 (mark), pulse coding rests with no pulse
  assign rest_lvl = ~cfg_irda ^ cfg_invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= {SYNC_STAGES{rest_lvl}};
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_pin};
  end

  // after polarity removal: NRZ logic level, or "pulse present" in pulse coding
  assign lvl = sync_q[SYNC_STAGES-1] ^ cfg_invert;

  // hold any pulse seen between two oversample strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pulse_q <= 1'b0;
    else if (os_tick)          pulse_q <= 1'b0;
    else if (cfg_irda && lvl)  pulse_q <= 1'b1;
  end

  assign samp_tick = os_tick;
  assign samp_bit  = cfg_irda ? ~(pulse_q | lvl) : lvl;
endmodule

// File: rtl/rxf_idle_det.sv
module rxf_idle_det #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_tick,
  input  logic samp_bit,
  input  logic in_idle,
  input  logic cfg_nine,
  output logic idle_hit
);
  import rxf_pkg::*;
  localparam int MAX_TICKS = (CHAR_W + 2) * OSR;
  localparam int IW        = $clog2(MAX_TICKS + 1);
  localparam int LIM9      = (CHAR_W + 2) * OSR;
  localparam int LIM8      = (CHAR_W + 1) * OSR;

  logic [IW-1:0] cnt_q;
  logic [IW-1:0] limit;
  logic          armed_q;
  logic          resting;

  assign limit   = cfg_nine ? IW'(LIM9) : IW'(LIM8);
  assign resting = samp_tick && in_idle && samp_bit;
  assign idle_hit = resting && armed_q && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (samp_tick) begin
      if (!resting) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (idle_hit) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else if (armed_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R10
  idle_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> !armed_q);
endmodule

// File: rtl/rxf_framer.sv
module rxf_framer #(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_tick,
  input  logic              samp_bit,
  input  logic              cfg_irda,
  input  logic              cfg_nine,
  input  logic              idle_hit,
  output logic              done,
  output rxf_pkg::rx_char_t done_char,
  output logic              busy,
  output logic              in_idle
);
  import rxf_pkg::*;
  localparam int CW = $clog2(OSR + 1);
  localparam int V0 = OSR / 2;
  localparam int IXW = $clog2(CHAR_W + 1);

  rx_state_e         st_q;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     n;
  logic [2:0]        vote_q;
  logic              and_q;
  logic [IXW-1:0]    idx_q;
  logic [IXW-1:0]    last_idx;
  logic [CHAR_W-1:0] bits_q;
  logic              ferr_q;
  logic              bit_now;
  logic              start_false;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  assign n           = cnt_q + 1'b1;
  assign last_idx    = cfg_nine ? IXW'(CHAR_W - 1) : IXW'(CHAR_W - 2);
  assign bit_now     = cfg_irda ? (and_q & samp_bit) : maj3(vote_q[0], vote_q[1], vote_q[2]);
  assign start_false = !cfg_irda && (st_q == ST_START) && (n == CW'(V0 + 2)) &&
                       maj3(vote_q[0], vote_q[1], samp_bit);
  assign in_idle     = (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      vote_q <= '0;
      and_q  <= 1'b1;
      idx_q  <= '0;
      bits_q <= '0;
      ferr_q <= 1'b0;
      done   <= 1'b0;
      busy   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (idle_hit) busy <= 1'b0;
      if (samp_tick) begin
        if (st_q == ST_IDLE) begin
          if (!samp_bit) begin
            st_q  <= ST_START;
            cnt_q <= CW'(1);
            and_q <= 1'b0;
            busy  <= 1'b1;
          end
        end else begin
          cnt_q <= n;
          and_q <= and_q & samp_bit;
          if (n == CW'(V0))     vote_q[0] <= samp_bit;
          if (n == CW'(V0 + 1)) vote_q[1] <= samp_bit;
          if (n == CW'(V0 + 2)) vote_q[2] <= samp_bit;
          if (start_false) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else if (n == CW'(OSR)) begin
            cnt_q <= '0;
            and_q <= 1'b1;
            unique case (st_q)
              ST_START: begin
                st_q   <= ST_DATA;
                idx_q  <= '0;
                bits_q <= '0;
              end
              ST_DATA: begin
                bits_q[idx_q] <= bit_now;
                if (idx_q == last_idx) st_q <= ST_STOP;
                else                   idx_q <= idx_q + 1'b1;
              end
              ST_STOP: begin
                done   <= 1'b1;
                ferr_q <= !bit_now;
                st_q   <= ST_IDLE;
              end
              default: st_q <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

  assign done_char.ferr = ferr_q;
  assign done_char.bits = bits_q;

  // R9
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(samp_tick) && !$past(samp_bit));
  // R10
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> !busy);
  // R1
  done_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st_q == ST_STOP) && st_q == ST_IDLE);
endmodule

// File: rtl/rxf_top.sv
module rxf_top #(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_pin,
  input  logic       cfg_irda,
  input  logic       cfg_invert,
  input  logic       cfg_nine,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_bit8,
  output logic       m_frame_err,
  output logic       rx_busy,
  output logic       idle_seen
);
  import rxf_pkg::*;

  logic     samp_tick;
  logic     samp_bit;
  logic     in_idle;
  logic     idle_hit;
  logic     done;
  rx_char_t done_char;
  rx_char_t out_q;

  rxf_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .os_tick(os_tick),
    .cfg_irda(cfg_irda), .cfg_invert(cfg_invert),
    .samp_tick(samp_tick), .samp_bit(samp_bit)
  );

  rxf_framer #(.OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .samp_bit(samp_bit),
    .cfg_irda(cfg_irda), .cfg_nine(cfg_nine), .idle_hit(idle_hit),
    .done(done), .done_char(done_char), .busy(rx_busy), .in_idle(in_idle)
  );

  rxf_idle_det #(.OSR(OSR)) u_idle (
    .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .samp_bit(samp_bit),
    .in_idle(in_idle), .cfg_nine(cfg_nine), .idle_hit(idle_hit)
  );

  // output register: keep a waiting character, drop one that arrives behind it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      out_q   <= '0;
    end else begin
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (done && (!m_valid || m_ready)) begin
        m_valid <= 1'b1;
        out_q   <= done_char;
      end
    end
  end

  assign m_data      = out_q.bits[7:0];
  assign m_bit8      = out_q.bits[8];
  assign m_frame_err = out_q.ferr;
  assign idle_seen   = idle_hit;

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_bit8) && $stable(m_frame_err));
  // R7
  bit8_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !cfg_nine |-> !m_bit8);
endmodule

// File: tb/rxf_top_bench.sv
`timescale 1ns/1ps
module rxf_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rx_pin = 1'b1;
  logic cfg_irda = 1'b0, cfg_invert = 1'b0, cfg_nine = 1'b0;
  logic m_ready = 1'b1;
  logic m_valid, m_bit8, m_frame_err, rx_busy, idle_seen;
  logic [7:0] m_data;

  int n_chk = 0, n_bad = 0, idle_cnt = 0;
  bit finished = 0;
  logic [9:0] rxq[$];

  always #2.5 clk = ~clk;

  rxf_top u_rxf_top (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_pin(rx_pin),
    .cfg_irda(cfg_irda), .cfg_invert(cfg_invert), .cfg_nine(cfg_nine),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_bit8(m_bit8),
    .m_frame_err(m_frame_err), .rx_busy(rx_busy), .idle_seen(idle_seen)
  );

  always @(negedge clk) begin
    #1;
    if (rst_n && m_valid && m_ready) rxq.push_back({m_frame_err, m_bit8, m_data});
    if (rst_n && idle_seen) idle_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic rest_level(input logic irda, input logic inv);
    return irda ? inv : ~inv;
  endfunction

  function automatic logic line_level(input logic b, input int t, input logic irda, input logic inv);
    if (irda) return ((b == 1'b0) && t >= 6 && t <= 8) ^ inv;
    return b ^ inv;
  endfunction

  function automatic logic [9:0] expect_word(input logic [8:0] d, input logic nine, input logic stp);
    return {~stp, nine ? d[8] : 1'b0, d[7:0]};
  endfunction

  task automatic slot(input logic lvl);
    rx_pin  = lvl;
    os_tick = 1'b0;
    repeat (3) @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk);
    os_tick = 1'b0;
  endtask

  task automatic rest(input int n);
    for (int i = 0; i < n; i++) slot(rest_level(cfg_irda, cfg_invert));
  endtask

  task automatic do_reset(input logic irda, input logic inv, input logic nine);
    rst_n = 1'b0;
    cfg_irda = irda; cfg_invert = inv; cfg_nine = nine;
    rx_pin = rest_level(irda, inv);
    os_tick = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rxq.delete();
    idle_cnt = 0;
  endtask

  // glitch_bit: data bit index to corrupt (-1 none); gmask: slots to flip in it
  task automatic send_frame(input logic [8:0] d, input logic stp, input int glitch_bit, input logic [15:0] gmask);
    int nb;
    logic b;
    logic lvl;
    nb = cfg_nine ? 9 : 8;
    for (int k = 0; k < nb + 2; k++) begin
      if (k == 0) b = 1'b0;
      else if (k == nb + 1) b = stp;
      else b = d[k-1];
      for (int t = 0; t < 16; t++) begin
        lvl = line_level(b, t, cfg_irda, cfg_invert);
        if (k - 1 == glitch_bit && gmask[t]) lvl = ~lvl;
        slot(lvl);
      end
    end
    rest(8);
  endtask

  task automatic expect_one(input string req, input logic [9:0] exp);
    check({req, " count"}, rxq.size(), 1);
    if (rxq.size() > 0) check(req, rxq.pop_front(), exp);
    rxq.delete();
  endtask

  initial begin
    logic [8:0] d;
    logic stp;
    logic [1:0] combo;
    void'($urandom(32'h5EED_1234));

    // R12 reset state
    do_reset(1'b0, 1'b0, 1'b0);
    check("R12 valid", m_valid, 0);
    check("R12 busy", rx_busy, 0);
    check("R12 idle", idle_seen, 0);

    // R1 R2 R3 R4 R7 R8: all codings, random data, lengths and stop bits
    for (int i = 0; i < 40; i++) begin
      if (i % 8 == 0) begin
        combo = 2'((i / 8) % 4);
        do_reset(combo[0], combo[1], 1'($urandom % 2));
        rest(4);
      end
      d   = 9'($urandom);
      stp = ($urandom % 6) != 0;
      send_frame(d, stp, -1, 16'h0);
      if (!cfg_irda) expect_one(cfg_invert ? "R2 R7 R8 nrz-inv" : "R1 R7 R8 nrz", expect_word(d, cfg_nine, stp));
      else           expect_one(cfg_invert ? "R4 R7 R8 pulse-inv" : "R3 R7 R8 pulse", expect_word(d, cfg_nine, stp));
    end

    // R7 directed, nine bits with top bit set
    do_reset(1'b0, 1'b0, 1'b1);
    rest(4);
    send_frame(9'h13C, 1'b1, -1, 16'h0);
    expect_one("R7 ninth", 10'h13C);
    // R8 break: all zeros including stop
    send_frame(9'h000, 1'b0, -1, 16'h0);
    expect_one("R8 break", 10'h200);

    // R5 majority vote
    do_reset(1'b0, 1'b0, 1'b0);
    rest(4);
    send_frame(9'h0A5, 1'b1, 2, 16'h0100);
    expect_one("R5 one-sample glitch", 10'h0A5);
    send_frame(9'h0A5, 1'b1, 2, 16'h0180);
    expect_one("R5 two-sample glitch", 10'h0A1);
    send_frame(9'h0A5, 1'b1, 3, 16'hFC7F);
    expect_one("R5 outside window", 10'h0A5);

    // R6 R9 R10: short low glitch, then rest
    do_reset(1'b0, 1'b0, 1'b0);
    rest(4);
    check("R9 busy before", rx_busy, 0);
    slot(1'b0);
    check("R9 busy on first zero", rx_busy, 1);
    slot(1'b0); slot(1'b0);
    rest(7);
    rest(159);
    check("R6 no char", rxq.size(), 0);
    check("R10 busy held at 159", rx_busy, 1);
    check("R10 no idle at 159", idle_cnt, 0);
    rest(1);
    check("R10 idle at 160", idle_cnt, 1);
    check("R10 busy cleared", rx_busy, 0);
    rest(200);
    check("R10 single pulse", idle_cnt, 1);

    // R11 back-pressure
    do_reset(1'b1, 1'b0, 1'b0);
    rest(4);
    m_ready = 1'b0;
    send_frame(9'h05A, 1'b1, -1, 16'h0);
    send_frame(9'h0C3, 1'b1, -1, 16'h0);
    check("R11 nothing taken", rxq.size(), 0);
    check("R11 valid held", m_valid, 1);
    check("R11 first kept", m_data, 8'h5A);
    m_ready = 1'b1;
    repeat (4) @(negedge clk);
    expect_one("R11 drain", 10'h05A);
    repeat (4) @(negedge clk);
    check("R11 second dropped", rxq.size(), 0);
    check("R11 valid low", m_valid, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL all requirements (watchdog): actual 190000 cycles expected fewer");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule